// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block moves 36-bit words from a producer clocked by `clk_a` to a consumer clocked by `clk_b`. The two clocks are unrelated. The storage holds 64 words. Each side has an active-low chip select, an enable and a direction input. A word moves only on a rising edge of that side's own clock, and only when the select, the enable and the direction all ask for it. Side A can only write and side B can only read. A command in the wrong direction does nothing.

All status outputs are active low. Side A gets a full flag and an almost-full flag. Side B gets an empty flag and an almost-empty flag. Each flag is built only from registers in the clock domain of the side that reads it. Pointers cross between the domains as 7-bit Gray codes through two flip-flop stages. When reset is released, a single threshold X is captured from a two-bit select input. Both almost flags compare against that same X.

A read loads the oldest stored word into an output register. The register keeps its value until the next read is accepted.

Top module: `dual_clock_fifo`

## Requirements
- R1: A write is accepted on a rising `clk_a` edge only when `a_cs_n`=0, `a_en`=1 and `a_wr`=1. A read is accepted on a rising `clk_b` edge only when `b_cs_n`=0, `b_en`=1 and `b_wr`=0. Any other combination stores nothing, removes nothing and leaves `b_dout` unchanged.
- R2: A write attempted while `full_n` is 0 is discarded and is never returned by a later read.
- R3: A read attempted while `empty_n` is 0 leaves `b_dout` unchanged and removes nothing.
- R4: Let N be the number of stored words as seen by side B. Once side B has had time to see the latest writes, `aempty_n` is 0 exactly when N is at most X.
- R5: Let F be the number of free locations (64 minus the stored count) as seen by side A. `afull_n` is 0 exactly when F is at most X. This rule also holds during reset, when F is 64 and `afull_n` is therefore 1.
- R6: X is captured on the rising edge of `rst_n` from `ofs_sel`. The codes are 00 for 16, 01 for 12, 10 for 8 and 11 for 4.
- R7: `empty_n` is 0 while `rst_n` is 0. When one word is written into an empty FIFO, `empty_n` is still 0 after the first rising `clk_b` edge following that write. It becomes 1 on the second rising `clk_b` edge.
- R8: `full_n` is 0 while `rst_n` is 0. After `rst_n` is released, `full_n` is still 0 after the first rising `clk_a` edge and becomes 1 on the second.
- R9: Words leave in the order they were accepted. Each accepted read puts the next word on `b_dout` right after that `clk_b` edge.
- R10: After 64 accepted writes with no reads, `full_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset; its rising edge captures `ofs_sel` |
| ofs_sel | input | 2 | Threshold select, captured when reset is released |
| a_cs_n | input | 1 | Side A chip select, active low |
| a_en | input | 1 | Side A enable |
| a_wr | input | 1 | Side A direction, 1 = write |
| a_din | input | 36 | Write data |
| full_n | output | 1 | Full flag, 0 = full, in the `clk_a` domain |
| afull_n | output | 1 | Almost-full flag, 0 = at most X free locations, in the `clk_a` domain |
| b_cs_n | input | 1 | Side B chip select, active low |
| b_en | input | 1 | Side B enable |
| b_wr | input | 1 | Side B direction, 0 = read |
| b_dout | output | 36 | Read data register |
| empty_n | output | 1 | Empty flag, 0 = empty, in the `clk_b` domain |
| aempty_n | output | 1 | Almost-empty flag, 0 = at most X words stored, in the `clk_b` domain |

## Verification
The bench builds the block with its default parameters: 36-bit words, a 6-bit address and the four preset thresholds 16, 12, 8 and 4. It uses clock periods of 10 ns and 14 ns, so rising edges of the two clocks never coincide. Because the depth is only 64, the bench can fill and drain the FIFO completely after each of the four resets, one per select code. This lets it probe each threshold on both sides of its boundary and write into a full FIFO. A random phase then drives both sides at once, so the Gray pointers pass through every wrap of the 7-bit count.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    // Threshold select codes captured at the end of reset
    typedef enum logic [1:0] {
        OFS_SEL_0 = 2'b00,
        OFS_SEL_1 = 2'b01,
        OFS_SEL_2 = 2'b10,
        OFS_SEL_3 = 2'b11
    } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] dout_d, dout_q;

    always_ff @(posedge wr_clk) begin
        if (wr_en) store_q[wr_addr] <= wr_data;
    end

    // Output register holds unless a read is accepted
    always_comb begin
        dout_d = rd_en ? store_q[rd_addr] : dout_q;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) dout_q <= '0;
        else           dout_q <= dout_d;
    end

    assign rd_data = dout_q;
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
    parameter int ADDR_W = 6,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [PTR_W-1:0]  rd_gray_sync,
    input  logic [PTR_W-1:0]  thresh,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PTR_W-1:0]  wr_gray,
    output logic              full_n,
    output logic              afull_n
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic [1:0]       arm;
    } wr_state_t;

    wr_state_t s_d, s_q;

    function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0] rd_bin, used, nxt_bin;
    logic [PTR_W:0]   free;
    logic             is_full, accept;

    always_comb begin
        rd_bin  = gray2bin(rd_gray_sync);
        is_full = (s_q.gray == {~rd_gray_sync[PTR_W-1:PTR_W-2], rd_gray_sync[PTR_W-3:0]});
        used    = s_q.bin - rd_bin;
        free    = (PTR_W + 1)'(DEPTH) - {1'b0, used};
        full_n  = s_q.arm[1] & ~is_full;
        afull_n = (free > {1'b0, thresh});
        accept  = push_req & full_n;
        nxt_bin = s_q.bin + 1'b1;

        s_d     = s_q;
        s_d.arm = {s_q.arm[0], 1'b1};
        if (accept) begin
            s_d.bin  = nxt_bin;
            s_d.gray = nxt_bin ^ (nxt_bin >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_en   = accept;
    assign wr_addr = s_q.bin[ADDR_W-1:0];
    assign wr_gray = s_q.gray;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
    parameter int ADDR_W = 6,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_req,
    input  logic [PTR_W-1:0]  wr_gray_sync,
    input  logic [PTR_W-1:0]  thresh,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  rd_gray,
    output logic              empty_n,
    output logic              aempty_n
);
    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
    } rd_state_t;

    rd_state_t s_d, s_q;

    function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0] wr_bin, used, nxt_bin;
    logic             accept;

    always_comb begin
        wr_bin   = gray2bin(wr_gray_sync);
        used     = wr_bin - s_q.bin;
        empty_n  = (s_q.gray != wr_gray_sync);
        aempty_n = (used > thresh);
        accept   = pop_req & empty_n;
        nxt_bin  = s_q.bin + 1'b1;

        s_d = s_q;
        if (accept) begin
            s_d.bin  = nxt_bin;
            s_d.gray = nxt_bin ^ (nxt_bin >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_en   = accept;
    assign rd_addr = s_q.bin[ADDR_W-1:0];
    assign rd_gray = s_q.gray;
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int ADDR_W      = 6,
    parameter int OFS_0       = 16,
    parameter int OFS_1       = 12,
    parameter int OFS_2       = 8,
    parameter int OFS_3       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              a_cs_n,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic [DATA_W-1:0] a_din,
    output logic              full_n,
    output logic              afull_n,
    input  logic              b_cs_n,
    input  logic              b_en,
    input  logic              b_wr,
    output logic [DATA_W-1:0] b_dout,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  ofs_d, ofs_q;
    logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_b, rd_gray_a;
    logic              push_req, pop_req, mem_wr_en, mem_rd_en;
    logic [ADDR_W-1:0] mem_wr_addr, mem_rd_addr;

    // Threshold chosen from the select pins, captured as reset is released
    always_comb begin
        unique case (ofs_sel_e'(ofs_sel))
            OFS_SEL_0: ofs_d = PTR_W'(OFS_0);
            OFS_SEL_1: ofs_d = PTR_W'(OFS_1);
            OFS_SEL_2: ofs_d = PTR_W'(OFS_2);
            OFS_SEL_3: ofs_d = PTR_W'(OFS_3);
        endcase
    end

    always_ff @(posedge rst_n) begin
        ofs_q <= ofs_d;
    end

    assign push_req = ~a_cs_n & a_en & a_wr;
    assign pop_req  = ~b_cs_n & b_en & ~b_wr;

    dcf_wr_ctl #(.ADDR_W(ADDR_W)) i_wr_ctl (
        .clk          (clk_a),
        .rst_n        (rst_n),
        .push_req     (push_req),
        .rd_gray_sync (rd_gray_a),
        .thresh       (ofs_q),
        .wr_en        (mem_wr_en),
        .wr_addr      (mem_wr_addr),
        .wr_gray      (wr_gray),
        .full_n       (full_n),
        .afull_n      (afull_n)
    );

    dcf_rd_ctl #(.ADDR_W(ADDR_W)) i_rd_ctl (
        .clk          (clk_b),
        .rst_n        (rst_n),
        .pop_req      (pop_req),
        .wr_gray_sync (wr_gray_b),
        .thresh       (ofs_q),
        .rd_en        (mem_rd_en),
        .rd_addr      (mem_rd_addr),
        .rd_gray      (rd_gray),
        .empty_n      (empty_n),
        .aempty_n     (aempty_n)
    );

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) i_sync_w2r (
        .clk   (clk_b),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_b)
    );

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) i_sync_r2w (
        .clk   (clk_a),
        .rst_n (rst_n),
        .d     (rd_gray),
        .q     (rd_gray_a)
    );

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
        .wr_clk   (clk_a),
        .wr_en    (mem_wr_en),
        .wr_addr  (mem_wr_addr),
        .wr_data  (a_din),
        .rd_clk   (clk_b),
        .rd_rst_n (rst_n),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_rd_addr),
        .rd_data  (b_dout)
    );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int PTR_W  = 7,
    parameter int DATA_W = 36
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst_n,
    input logic              a_cs_n,
    input logic              b_cs_n,
    input logic              full_n,
    input logic              empty_n,
    input logic              aempty_n,
    input logic [PTR_W-1:0]  wr_gray,
    input logic [PTR_W-1:0]  rd_gray,
    input logic [DATA_W-1:0] b_dout
);
    // R1
    a_idle_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_cs_n |=> $stable(wr_gray));

    // R1
    b_idle_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        b_cs_n |=> ($stable(rd_gray) && $stable(b_dout)));

    // R2
    no_overflow_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !full_n |=> $stable(wr_gray));

    // R3
    no_underflow_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !empty_n |=> ($stable(rd_gray) && $stable(b_dout)));

    // R4
    empty_means_aempty_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R9
    wr_gray_step_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R9
    rd_gray_step_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind dual_clock_fifo dcf_checker #(.PTR_W(PTR_W), .DATA_W(DATA_W)) i_dcf_checker (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_n    (rst_n),
    .a_cs_n   (a_cs_n),
    .b_cs_n   (b_cs_n),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .aempty_n (aempty_n),
    .wr_gray  (wr_gray),
    .rd_gray  (rd_gray),
    .b_dout   (b_dout)
);

// File: tb/test_dual_clock_fifo.sv
module test_dual_clock_fifo;
    localparam int CLK_A_PERIOD = 10;
    localparam int CLK_B_PERIOD = 14;
    localparam int DEPTH        = 64;
    localparam int DW           = 36;

    logic          clk_a, clk_b, rst_n;
    logic [1:0]    ofs_sel;
    logic          a_cs_n, a_en, a_wr;
    logic [DW-1:0] a_din;
    logic          full_n, afull_n;
    logic          b_cs_n, b_en, b_wr;
    logic [DW-1:0] b_dout;
    logic          empty_n, aempty_n;

    int            n_vec, n_bad, x_cur, b_edges;
    logic [DW-1:0] model_q[$];

    dual_clock_fifo i_dual_clock_fifo (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_din(a_din),
        .full_n(full_n), .afull_n(afull_n),
        .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_dout(b_dout),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    initial begin
        clk_a = 1'b0;
        forever #(CLK_A_PERIOD / 2) clk_a = ~clk_a;
    end

    initial begin
        clk_b = 1'b0;
        #1;
        forever #(CLK_B_PERIOD / 2) clk_b = ~clk_b;
    end

    initial b_edges = 0;
    always @(posedge clk_b) b_edges <= b_edges + 1;

    function automatic int offset_of(input int sel);
        case (sel)
            0: return 16;
            1: return 12;
            2: return 8;
            default: return 4;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_a();
        a_cs_n = 1'b1; a_en = 1'b0; a_wr = 1'b0;
    endtask

    task automatic idle_b();
        b_cs_n = 1'b1; b_en = 1'b0; b_wr = 1'b1;
    endtask

    task automatic push_try(input bit cs_n, input bit en, input bit wr, input logic [DW-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_en = en; a_wr = wr; a_din = d;
        if (!cs_n && en && wr && full_n) model_q.push_back(d);
        @(negedge clk_a);
        idle_a();
    endtask

    task automatic pop_try(input bit cs_n, input bit en, input bit wr);
        bit ok;
        logic [DW-1:0] held, exp;
        @(negedge clk_b);
        b_cs_n = cs_n; b_en = en; b_wr = wr;
        ok   = !cs_n && en && !wr && empty_n;
        held = b_dout;
        @(posedge clk_b);
        #1;
        idle_b();
        if (ok) begin
            exp = model_q.pop_front();
            check(b_dout == exp, "R9 read order", 64'(b_dout), 64'(exp));
        end else if (!cs_n && en && !wr) begin
            check(b_dout == held, "R3 read on empty", 64'(b_dout), 64'(held));
        end else begin
            check(b_dout == held, "R1 disabled read", 64'(b_dout), 64'(held));
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk_a);
        repeat (5) @(posedge clk_b);
        #1;
    endtask

    task automatic flag_check();
        int n;
        settle();
        n = model_q.size();
        check(empty_n == (n != 0), "R7 empty level", 64'(empty_n), 64'(n != 0));
        check(full_n == (n != DEPTH), "R10 full level", 64'(full_n), 64'(n != DEPTH));
        check(aempty_n == (n > x_cur), "R4 R6 almost-empty", 64'(aempty_n), 64'(n > x_cur));
        check(afull_n == ((DEPTH - n) > x_cur), "R5 R6 almost-full", 64'(afull_n), 64'((DEPTH - n) > x_cur));
    endtask

    task automatic do_reset(input int sel);
        @(negedge clk_a);
        rst_n = 1'b0;
        idle_a(); idle_b();
        ofs_sel = 2'(sel);
        repeat (3) @(negedge clk_a);
        check(empty_n == 1'b0, "R7 empty in reset", 64'(empty_n), 64'd0);
        check(full_n == 1'b0, "R8 full in reset", 64'(full_n), 64'd0);
        check(afull_n == 1'b1, "R5 almost-full in reset", 64'(afull_n), 64'd1);
        model_q.delete();
        x_cur = offset_of(sel);
        rst_n = 1'b1;
        @(posedge clk_a); #1;
        check(full_n == 1'b0, "R8 full after 1st edge", 64'(full_n), 64'd0);
        @(posedge clk_a); #1;
        check(full_n == 1'b1, "R8 full after 2nd edge", 64'(full_n), 64'd1);
    endtask

    task automatic first_word_timing(input logic [DW-1:0] d);
        int b0;
        settle();
        @(negedge clk_a);
        a_cs_n = 1'b0; a_en = 1'b1; a_wr = 1'b1; a_din = d;
        model_q.push_back(d);
        @(posedge clk_a);
        b0 = b_edges;
        #1;
        idle_a();
        wait (b_edges == b0 + 1);
        #1;
        check(empty_n == 1'b0, "R7 empty after 1st read edge", 64'(empty_n), 64'd0);
        wait (b_edges == b0 + 2);
        #1;
        check(empty_n == 1'b1, "R7 empty after 2nd read edge", 64'(empty_n), 64'd1);
    endtask

    task automatic fill_to(input int n, inout int tag);
        while (model_q.size() < n) begin
            push_try(1'b0, 1'b1, 1'b1, DW'(tag));
            tag++;
        end
    endtask

    task automatic directed(input int sel);
        int tag;
        tag = (sel << 12) + 1;
        do_reset(sel);
        first_word_timing(DW'(36'hA_0000_0000) | DW'(sel));
        // R1: masked writes and reads are all ignored
        push_try(1'b1, 1'b1, 1'b1, 36'hBAD00_0001);
        push_try(1'b0, 1'b0, 1'b1, 36'hBAD00_0002);
        push_try(1'b0, 1'b1, 1'b0, 36'hBAD00_0003);
        pop_try(1'b1, 1'b1, 1'b0);
        pop_try(1'b0, 1'b0, 1'b0);
        pop_try(1'b0, 1'b1, 1'b1);
        flag_check();
        fill_to(x_cur, tag);
        flag_check();
        fill_to(x_cur + 1, tag);
        flag_check();
        fill_to(DEPTH - x_cur - 1, tag);
        flag_check();
        fill_to(DEPTH - x_cur, tag);
        flag_check();
        fill_to(DEPTH, tag);
        flag_check();
        // R2: write into a full FIFO is dropped
        push_try(1'b0, 1'b1, 1'b1, 36'hF_FFFF_FFFF);
        check(model_q.size() == DEPTH, "R2 model depth", 64'(model_q.size()), 64'(DEPTH));
        flag_check();
        while (model_q.size() > 0) pop_try(1'b0, 1'b1, 1'b0);
        flag_check();
        // R3: read from an empty FIFO holds the output
        pop_try(1'b0, 1'b1, 1'b0);
        pop_try(1'b0, 1'b1, 1'b0);
    endtask

    task automatic rand_writer(input int n);
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] d;
            bit cs_n, en, wr;
            d    = {$urandom, $urandom}[DW-1:0];
            cs_n = ($urandom % 8) == 0;
            en   = ($urandom % 8) != 0;
            wr   = ($urandom % 8) != 0;
            push_try(cs_n, en, wr, d);
        end
    endtask

    task automatic rand_reader(input int n);
        for (int i = 0; i < n; i++) begin
            bit cs_n, en, wr;
            cs_n = ($urandom % 8) == 0;
            en   = ($urandom % 8) != 0;
            wr   = ($urandom % 8) == 0;
            pop_try(cs_n, en, wr);
        end
    endtask

    initial begin
        n_vec = 0; n_bad = 0; x_cur = 16;
        rst_n = 1'b1; ofs_sel = 2'b00; a_din = '0;
        idle_a(); idle_b();
        void'($urandom(32'd20240611));
        for (int s = 0; s < 4; s++) directed(s);
        do_reset(1);
        fork
            rand_writer(700);
            rand_reader(600);
        join
        settle();
        while (model_q.size() > 0) pop_try(1'b0, 1'b1, 1'b0);
        flag_check();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_a);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule